// File: doc/BRIEF.md
# Serial Byte Receiver with Qualified Interrupt

This block receives asynchronous serial frames of one start bit, eight data bits sent least-significant bit first, no parity and one stop bit. It runs from the system clock. A programmable divisor sets the oversampling tick, and there are sixteen ticks per bit. The line is synchronised by two flops. A falling edge starts a frame, and the start bit is confirmed at mid-bit. Each bit is then decided by a three-sample majority vote near its centre.

At the centre of the stop bit, the assembled byte is copied in one parallel step into a holding register, and a ready flag rises. The interrupt output follows after a qualification delay of 7/8 of a bit plus three system clocks. The receiver returns to hunting for the next start edge at the stop-bit centre. It does not wait for the holding register to be read or the interrupt to be taken. Frames separated by a single stop bit therefore never drift out of alignment.

A read strobe takes the byte and clears both ready and the interrupt. A clear strobe resets the overrun and framing flags.

Top module: `uart_rx_dbuf`

## Requirements
- R1: While reset is held, rx_ready, rx_irq, overrun_err and framing_err are all 0.
- R2: For any baud_div value D, a bit lasts 16*(D+1) clocks. A frame is a low start bit, then data bit 0 first through bit 7, then a high stop bit. After the stop bit ends, rx_data holds the byte and rx_ready is 1.
- R3: rx_ready rises during the stop bit: more than 9 and fewer than 10 bit periods after the start edge. At that moment rx_irq is still 0.
- R4: If the byte is not read, rx_irq rises exactly 14*(D+1)+3 clocks after rx_ready rises.
- R5: A one-clock rd_strobe clears rx_ready and rx_irq. If the read comes before the delay of R4 expires, rx_irq does not assert for that byte.
- R6: If a frame completes while rx_ready is still 1 and no read occurs in that cycle, overrun_err becomes 1. rx_data takes the newer byte.
- R7: If the stop bit is sampled low, framing_err becomes 1. The byte is still transferred and rx_ready is set.
- R8: A one-clock err_clr returns overrun_err and framing_err to 0. It leaves rx_data and rx_ready unchanged.
- R9: A low pulse shorter than half a bit period on an idle line is rejected. rx_ready stays 0, and rx_data keeps its value.
- R10: Frames sent back to back with one stop bit are each received correctly while the previous byte is unread and rx_irq is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div | input | DIV_W | Clocks per oversampling tick, minus one |
| rx_in | input | 1 | Serial line, idle high |
| rd_strobe | input | 1 | One-clock read of the holding register |
| err_clr | input | 1 | One-clock clear of the error flags |
| rx_data | output | DATA_W | Holding register |
| rx_ready | output | 1 | Unread byte present |
| rx_irq | output | 1 | Qualified receive interrupt |
| overrun_err | output | 1 | A byte was overwritten before being read |
| framing_err | output | 1 | A stop bit was sampled low |

## Verification
The bench sweeps four divisor values. At each value it sends a fixed set of extreme and alternating bytes: all zeros, all ones, 0x55, 0xAA and single-bit values. These separate bit-order faults from vote faults and from sampling drift. At the smallest divisor it also sends all 256 byte values back to back.

Unread streams show whether re-arming depends on the read or the interrupt: a late re-arm corrupts the second and third bytes. Timed frames measure the exact ready-to-interrupt distance. A low stop bit, and a quarter-bit glitch, distinguish framing detection from false-start rejection.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_s,
  output logic line_fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= line_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign line_s    = s2_q;
  assign line_fall = s3_q & ~s2_q;
endmodule

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             wrap;

  assign wrap = (cnt_q == div);
  assign tick = wrap & ~restart;

  always_comb begin
    if (restart || wrap) cnt_n = '0;
    else                 cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_s,
  input  logic              rx_fall,
  input  logic              tick,
  output logic              restart,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output logic              ferr
);
  localparam int OSW = $clog2(OS_RATE);
  localparam int IW  = $clog2(DATA_W);
  localparam logic [OSW-1:0] OS_MID  = OSW'(OS_RATE / 2 - 1);
  localparam logic [OSW-1:0] OS_V0   = OSW'(OS_RATE - 3);
  localparam logic [OSW-1:0] OS_V1   = OSW'(OS_RATE - 2);
  localparam logic [OSW-1:0] OS_END  = OSW'(OS_RATE - 1);
  localparam logic [IW-1:0]  IDX_END = IW'(DATA_W - 1);

  rx_state_t         st_q, st_n;
  logic [OSW-1:0]    os_q, os_n;
  logic [IW-1:0]     idx_q, idx_n;
  logic              v0_q, v0_n, v1_q, v1_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic              done_q, done_n, ferr_q, ferr_n;
  logic              vote;

  assign vote = maj3(v0_q, v1_q, rx_s);

  always_comb begin
    st_n    = st_q;
    os_n    = os_q;
    idx_n   = idx_q;
    v0_n    = v0_q;
    v1_n    = v1_q;
    sh_n    = sh_q;
    ferr_n  = ferr_q;
    done_n  = 1'b0;
    restart = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (rx_fall) begin
          st_n    = RX_START;
          os_n    = '0;
          restart = 1'b1;
        end
      end
      RX_START: begin
        if (tick) begin
          if (os_q == OS_MID) begin
            if (!rx_s) begin
              st_n  = RX_DATA;
              os_n  = '0;
              idx_n = '0;
            end else begin
              st_n = RX_IDLE;
            end
          end else begin
            os_n = os_q + 1'b1;
          end
        end
      end
      RX_DATA, RX_STOP: begin
        if (tick) begin
          os_n = os_q + 1'b1;
          if (os_q == OS_V0) v0_n = rx_s;
          if (os_q == OS_V1) v1_n = rx_s;
          if (os_q == OS_END) begin
            if (st_q == RX_DATA) begin
              sh_n = {vote, sh_q[DATA_W-1:1]};
              if (idx_q == IDX_END) st_n = RX_STOP;
              else                  idx_n = idx_q + 1'b1;
            end else begin
              done_n = 1'b1;
              ferr_n = ~vote;
              st_n   = RX_IDLE;
            end
          end
        end
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      os_q   <= '0;
      idx_q  <= '0;
      v0_q   <= 1'b1;
      v1_q   <= 1'b1;
      sh_q   <= '0;
      done_q <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      os_q   <= os_n;
      idx_q  <= idx_n;
      v0_q   <= v0_n;
      v1_q   <= v1_n;
      sh_q   <= sh_n;
      done_q <= done_n;
      ferr_q <= ferr_n;
    end
  end

  assign done = done_q;
  assign dout = sh_q;
  assign ferr = ferr_q;
endmodule

// File: rtl/uart_rx_qual.sv
module uart_rx_qual #(
  parameter int DIV_W       = 8,
  parameter int QUAL_TICKS  = 14,
  parameter int EXTRA_CLKS  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             load,
  output logic             fire
);
  localparam int CW = DIV_W + $clog2(QUAL_TICKS + 1) + 2;

  logic [CW-1:0] cnt_q, cnt_n, div_ext, span;

  assign div_ext = {{(CW-DIV_W){1'b0}}, div};
  assign span    = (div_ext + 1'b1) * CW'(QUAL_TICKS) + CW'(EXTRA_CLKS);
  assign fire    = (cnt_q == CW'(1));

  always_comb begin
    if (load)             cnt_n = span;
    else if (cnt_q != '0) cnt_n = cnt_q - 1'b1;
    else                  cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/uart_rx_dbuf.sv
module uart_rx_dbuf #(
  parameter int DATA_W   = 8,
  parameter int DIV_W    = 8,
  parameter int OS_RATE  = 16,
  parameter int QUAL_NUM = 7,
  parameter int QUAL_DEN = 8,
  parameter int SYNC_PAD = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rx_in,
  input  logic              rd_strobe,
  input  logic              err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              rx_irq,
  output logic              overrun_err,
  output logic              framing_err
);
  localparam int QUAL_TICKS = OS_RATE * QUAL_NUM / QUAL_DEN;

  logic              rx_s, rx_fall, tick, restart;
  logic              frame_done, frame_ferr, qual_fire;
  logic [DATA_W-1:0] frame_byte;

  logic [DATA_W-1:0] data_q, data_n;
  logic              rdy_q, rdy_n, irq_q, irq_n, ovr_q, ovr_n, fe_q, fe_n;

  uart_rx_sync u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(rx_in), .line_s(rx_s), .line_fall(rx_fall)
  );

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .restart(restart), .tick(tick)
  );

  uart_rx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
    .clk(clk), .rst_n(rst_n), .rx_s(rx_s), .rx_fall(rx_fall), .tick(tick),
    .restart(restart), .done(frame_done), .dout(frame_byte), .ferr(frame_ferr)
  );

  uart_rx_qual #(.DIV_W(DIV_W), .QUAL_TICKS(QUAL_TICKS), .EXTRA_CLKS(SYNC_PAD)) u_qual (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .load(frame_done), .fire(qual_fire)
  );

  always_comb begin
    data_n = frame_done ? frame_byte : data_q;

    rdy_n = rdy_q;
    if (rd_strobe)  rdy_n = 1'b0;
    if (frame_done) rdy_n = 1'b1;

    irq_n = irq_q;
    if (qual_fire && rdy_q) irq_n = 1'b1;
    if (rd_strobe)          irq_n = 1'b0;

    ovr_n = ovr_q;
    if (err_clr)                             ovr_n = 1'b0;
    if (frame_done && rdy_q && !rd_strobe)   ovr_n = 1'b1;

    fe_n = fe_q;
    if (err_clr)                  fe_n = 1'b0;
    if (frame_done && frame_ferr) fe_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      irq_q  <= 1'b0;
      ovr_q  <= 1'b0;
      fe_q   <= 1'b0;
    end else begin
      data_q <= data_n;
      rdy_q  <= rdy_n;
      irq_q  <= irq_n;
      ovr_q  <= ovr_n;
      fe_q   <= fe_n;
    end
  end

  assign rx_data     = data_q;
  assign rx_ready    = rdy_q;
  assign rx_irq      = irq_q;
  assign overrun_err = ovr_q;
  assign framing_err = fe_q;
endmodule

// File: rtl/uart_rx_dbuf_chk.sv
module uart_rx_dbuf_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_strobe,
  input logic              err_clr,
  input logic              frame_done,
  input logic              frame_ferr,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_ready,
  input logic              rx_irq,
  input logic              overrun_err,
  input logic              framing_err
);
  // R2: holding register changes only on a completed frame
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(rx_data));

  // R3: interrupt never rises without ready already set
  p_ready_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(rx_ready));

  // R5: read clears interrupt; interrupt implies ready
  p_read_clears_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !rx_irq);
  p_read_clears_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !frame_done |=> !rx_ready);
  p_irq_has_rdy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ready);

  // R6: completing onto an unread byte flags overrun
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && rx_ready && !rd_strobe |=> overrun_err);

  // R7: bad stop bit flags framing error and still delivers
  p_framing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && frame_ferr |=> framing_err && rx_ready);

  // R8: clear strobe drops both error flags
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr && !frame_done |=> !overrun_err && !framing_err);
endmodule

bind uart_rx_dbuf uart_rx_dbuf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .err_clr(err_clr),
  .frame_done(frame_done), .frame_ferr(frame_ferr), .rx_data(rx_data),
  .rx_ready(rx_ready), .rx_irq(rx_irq), .overrun_err(overrun_err),
  .framing_err(framing_err)
);

// File: tb/uart_rx_dbuf_bench.sv
module uart_rx_dbuf_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] baud_div;
  logic       rx_in, rd_strobe, err_clr;
  logic [7:0] rx_data;
  logic       rx_ready, rx_irq, overrun_err, framing_err;

  int errors = 0;
  int checks = 0;
  int dv = 0;
  int bt = 16;

  always #5 clk = ~clk;
  assign baud_div = dv[7:0];

  uart_rx_dbuf u_uart_rx_dbuf (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_in(rx_in),
    .rd_strobe(rd_strobe), .err_clr(err_clr), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_irq(rx_irq), .overrun_err(overrun_err),
    .framing_err(framing_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (div=%0d)", req, act, exp, dv);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic stop);
    rx_in = 1'b0;
    @(negedge clk);
    rd_strobe = 1'b0;
    err_clr   = 1'b0;
    repeat (bt - 1) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i];
      repeat (bt) @(negedge clk);
    end
    rx_in = stop;
    repeat (bt) @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic do_read();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic do_clear();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
  endtask

  task automatic measure(input logic [7:0] b);
    int t_rdy;
    int t_irq;
    int irq_at_rdy;
    t_rdy = 0;
    t_irq = 0;
    irq_at_rdy = 0;
    fork
      send_byte(b, 1'b1);
      begin
        while (!rx_ready && t_rdy < 20 * bt) begin
          @(negedge clk);
          t_rdy++;
        end
        irq_at_rdy = int'(rx_irq);
        while (!rx_irq && t_irq < 4 * bt) begin
          @(negedge clk);
          t_irq++;
        end
      end
    join
    chk("R3 ready after 9 bits", int'(t_rdy > 9 * bt), 1);
    chk("R3 ready before 10 bits", int'(t_rdy < 10 * bt), 1);
    chk("R3 irq low when ready rises", irq_at_rdy, 0);
    chk("R4 ready-to-irq clocks", t_irq, 14 * (dv + 1) + 3);
    chk("R2 measured byte", int'(rx_data), int'(b));
    do_read();
    chk("R5 read clears ready", int'(rx_ready), 0);
    chk("R5 read clears irq", int'(rx_irq), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] pats [8];
    pats = '{8'h00, 8'hFF, 8'h55, 8'hAA, 8'h31, 8'h0D, 8'h80, 8'h01};
    rx_in = 1'b1;
    rd_strobe = 1'b0;
    err_clr = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", int'(rx_ready), 0);
    chk("R1 irq in reset", int'(rx_irq), 0);
    chk("R1 overrun in reset", int'(overrun_err), 0);
    chk("R1 framing in reset", int'(framing_err), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int d = 0; d < 4; d++) begin
      dv = d;
      bt = 16 * (d + 1);
      repeat (2 * bt) @(negedge clk);

      // R2: back-to-back patterns, each read before the next completes
      for (int k = 0; k < 8; k++) begin
        send_byte(pats[k], 1'b1);
        chk("R2 ready", int'(rx_ready), 1);
        chk("R2 byte", int'(rx_data), int'(pats[k]));
        rd_strobe = 1'b1;
      end
      @(negedge clk);
      rd_strobe = 1'b0;
      repeat (bt * 2) @(negedge clk);
      chk("R5 early read suppresses irq", int'(rx_irq), 0);
      chk("R5 ready cleared", int'(rx_ready), 0);
      chk("R6 no overrun when read", int'(overrun_err), 0);

      measure(8'hC3);

      // R10 / R6: unread back-to-back stream
      send_byte(8'h3C, 1'b1);
      chk("R10 first unread byte", int'(rx_data), 8'h3C);
      chk("R6 no overrun yet", int'(overrun_err), 0);
      send_byte(8'hE7, 1'b1);
      chk("R10 second byte while irq pending", int'(rx_data), 8'hE7);
      chk("R6 overrun flagged", int'(overrun_err), 1);
      send_byte(8'h42, 1'b1);
      chk("R10 third byte", int'(rx_data), 8'h42);
      repeat (bt) @(negedge clk);
      chk("R10 irq still pending", int'(rx_irq), 1);
      do_read();
      do_clear();
      chk("R8 overrun cleared", int'(overrun_err), 0);
      chk("R8 data kept", int'(rx_data), 8'h42);

      // R7: low stop bit
      send_byte(8'h5A, 1'b0);
      repeat (bt) @(negedge clk);
      chk("R7 framing flagged", int'(framing_err), 1);
      chk("R7 byte transferred", int'(rx_data), 8'h5A);
      chk("R7 ready set", int'(rx_ready), 1);
      do_clear();
      chk("R8 framing cleared", int'(framing_err), 0);
      chk("R8 ready kept", int'(rx_ready), 1);
      do_read();

      // R9: short glitch rejected
      rx_in = 1'b0;
      repeat (4 * (d + 1)) @(negedge clk);
      rx_in = 1'b1;
      repeat (2 * bt) @(negedge clk);
      chk("R9 glitch gives no ready", int'(rx_ready), 0);
      chk("R9 data unchanged", int'(rx_data), 8'h5A);
      send_byte(8'h96, 1'b1);
      chk("R9 next frame intact", int'(rx_data), 8'h96);
      do_read();
      repeat (bt) @(negedge clk);
    end

    // R2: all byte values at the fastest rate
    dv = 0;
    bt = 16;
    repeat (2 * bt) @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      send_byte(v[7:0], 1'b1);
      chk("R2 sweep byte", int'(rx_data), v);
      rd_strobe = 1'b1;
    end
    @(negedge clk);
    rd_strobe = 1'b0;
    repeat (2 * bt) @(negedge clk);
    chk("R6 sweep no overrun", int'(overrun_err), 0);
    chk("R7 sweep no framing", int'(framing_err), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule